// File: doc/BRIEF.md
# MDIO Management Master Controller

This block runs single management transactions on an MDIO/MDC serial bus towards Ethernet PHYs. It supports both the Clause 22 and the Clause 45 frame formats. Software programs a small register file through a simple word-wide write port and a combinational read port. Writing the command word with its start bit set launches exactly one 64-bit bus frame. The start bit reads back as 1 for the whole frame, so it doubles as the busy flag.

The controller derives MDC from the system clock with a fixed divider. It shifts the frame out MSB first and changes MDIO only on MDC falling edges. For reads, it releases MDIO from the turnaround onward and samples the PHY on MDC rising edges. When a read frame ends, the returned halfword lands in the read-data register, and a status bit reports whether the PHY failed to pull the second turnaround bit low. Any sequencing of Clause 45 address frames followed by data frames is left to software.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, every register reads 0, MDC is low and the MDIO output enable is low.
- R2: Register offsets are: command 0x0, frame address 0x4, write data 0x8, read data 0xC and status 0x10. The 0x4, 0x8 and 0xC registers hold 16 bits, and their upper bits read 0. In the command word, [4:0] is the register/device address, [9:5] is the PHY address, [11:10] is the opcode, [13:12] is the frame type and bit 14 is start.
- R3: A command write with bit 14 set while idle launches one frame, and bit 14 reads 1 until that frame ends. A command write with bit 14 clear stores the fields and launches nothing.
- R4: A frame is 64 MDC periods long and is sent MSB first. It consists of 32 ones, a start code, the 2-bit opcode, the 5-bit PHY address, the 5-bit register/device address, a 2-bit turnaround and 16 data bits. The start code is 00 when the frame type is 0 (Clause 45) and 01 for any other frame type (Clause 22).
- R5: Write frames send turnaround 10. A Clause 45 opcode 0 frame (address) sends the frame address register. Every other write frame sends the write-data register.
- R6: The read frames are Clause 22 opcode 2 and Clause 45 opcodes 2 and 3. From the first turnaround bit to the end of a read frame the output enable is low, and the 16 bits sampled on MDC rising edges appear in read data when the frame ends.
- R7: Status bit 0 takes the value of the second turnaround bit sampled at the end of each read frame, so 1 means the read failed. Write frames leave the status bit unchanged.
- R8: Each MDC level lasts HALF_DIV system clocks. MDC is low when idle. During a frame, MDIO and its enable change only on MDC falling edges.
- R9: A command write while a frame is running changes no command field and starts no further frame.
- R10: The MDIO output enable is low whenever the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register read data for reg_addr_i |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions take it for granted that mdio_i is a settled value whenever a rising MDC strobe samples it. They also take it for granted that register writes are single-cycle strobes whose offset is one of the five decoded words. The bench's PHY responder changes its bit only just after an MDC rising edge, so each bit is stable for a full MDC period before it is sampled. The bench issues writes one cycle wide at falling system-clock edges. The only overlapping command it sends is the deliberate one inside a running frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DW         = 16;
  localparam int FRAME_LEN  = 64;
  localparam int PRE_LEN    = 32;
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;
  localparam int REG_ADDR_W = 5;
  localparam int CMD_START  = 14;

  localparam int OFS_CMD  = 'h00;
  localparam int OFS_ADDR = 'h04;
  localparam int OFS_WDAT = 'h08;
  localparam int OFS_RDAT = 'h0C;
  localparam int OFS_STAT = 'h10;

  typedef struct packed {
    logic [1:0] ft;
    logic [1:0] op;
    logic [4:0] prt;
    logic [4:0] dev;
  } cmd_t;

  function automatic logic is_c45(cmd_t c);
    return c.ft == 2'd0;
  endfunction

  function automatic logic is_read(cmd_t c);
    return is_c45(c) ? c.op[1] : (c.op == 2'd2);
  endfunction

  function automatic logic [FRAME_LEN-1:0] build_frame(cmd_t c, logic [DW-1:0] d);
    logic [1:0] st;
    logic [1:0] ta;
    st = is_c45(c) ? 2'b00 : 2'b01;
    ta = is_read(c) ? 2'b11 : 2'b10;
    return {{PRE_LEN{1'b1}}, st, c.op, c.prt, c.dev, ta, d};
  endfunction
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = REG_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              done_i,
  input  logic              rd_frame_i,
  input  logic [DW-1:0]     cap_i,
  input  logic              fail_i,
  output cmd_t              cmd_o,
  output logic              busy_o,
  output logic              go_o,
  output logic [DW-1:0]     faddr_o,
  output logic [DW-1:0]     wdat_o,
  output logic              stat_o,
  output logic [REG_W-1:0]  rdata_o
);
  cmd_t          cmd_q;
  logic          busy_q, go_q, stat_q;
  logic [DW-1:0] faddr_q, wdat_q, rdat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      busy_q  <= 1'b0;
      go_q    <= 1'b0;
      stat_q  <= 1'b0;
      faddr_q <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
    end else begin
      go_q <= 1'b0;
      if (wr_i) begin
        if (addr_i == ADDR_W'(OFS_CMD)) begin
          if (!busy_q) begin
            cmd_q <= cmd_t'(wdata_i[CMD_START-1:0]);
            if (wdata_i[CMD_START]) begin
              busy_q <= 1'b1;
              go_q   <= 1'b1;
            end
          end
        end else if (addr_i == ADDR_W'(OFS_ADDR)) begin
          faddr_q <= wdata_i[DW-1:0];
        end else if (addr_i == ADDR_W'(OFS_WDAT)) begin
          wdat_q <= wdata_i[DW-1:0];
        end
      end
      if (done_i) begin
        busy_q <= 1'b0;
        if (rd_frame_i) begin
          rdat_q <= cap_i;
          stat_q <= fail_i;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_CMD))       rdata_o = REG_W'({busy_q, cmd_q});
    else if (addr_i == ADDR_W'(OFS_ADDR)) rdata_o = REG_W'(faddr_q);
    else if (addr_i == ADDR_W'(OFS_WDAT)) rdata_o = REG_W'(wdat_q);
    else if (addr_i == ADDR_W'(OFS_RDAT)) rdata_o = REG_W'(rdat_q);
    else if (addr_i == ADDR_W'(OFS_STAT)) rdata_o = REG_W'(stat_q);
  end

  assign cmd_o   = cmd_q;
  assign busy_o  = busy_q;
  assign go_o    = go_q;
  assign faddr_o = faddr_q;
  assign wdat_o  = wdat_q;
  assign stat_o  = stat_q;
endmodule

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          term;

  assign term = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // strobes mark the edge at which mdc_q toggles
  assign rise_o = run_i && term && !mdc_q;
  assign fall_o = run_i && term && mdc_q;
  assign mdc_o  = mdc_q;
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 go_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  input  logic                 rd_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 mdio_i,
  output logic                 act_o,
  output logic                 mdio_o,
  output logic                 oe_o,
  output logic                 done_o,
  output logic                 rd_o,
  output logic [DW-1:0]        cap_o,
  output logic                 fail_o
);
  localparam int IW = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] sh_q;
  logic [IW-1:0]        idx_q;
  logic                 act_q, rd_q, out_q, oe_q, fail_q;
  logic [DW-1:0]        cap_q;
  logic                 last;

  assign last = (idx_q == IW'(FRAME_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      idx_q  <= '0;
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      out_q  <= 1'b1;
      oe_q   <= 1'b0;
      fail_q <= 1'b0;
      cap_q  <= '0;
    end else if (go_i) begin
      act_q  <= 1'b1;
      sh_q   <= frame_i;
      idx_q  <= '0;
      out_q  <= frame_i[FRAME_LEN-1];
      oe_q   <= 1'b1;
      rd_q   <= rd_i;
      fail_q <= 1'b0;
    end else if (act_q) begin
      if (rise_i && rd_q) begin
        if (idx_q == IW'(TA_IDX + 1)) fail_q <= mdio_i;
        if (idx_q >= IW'(DATA_IDX))   cap_q  <= {cap_q[DW-2:0], mdio_i};
      end
      if (fall_i) begin
        if (last) begin
          act_q <= 1'b0;
          oe_q  <= 1'b0;
          out_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
          out_q <= sh_q[FRAME_LEN-2];
          // release the line from the first turnaround bit of a read
          oe_q  <= !(rd_q && (idx_q >= IW'(TA_IDX - 1)));
        end
      end
    end
  end

  assign done_o = act_q && fall_i && last;
  assign act_o  = act_q;
  assign mdio_o = out_q;
  assign oe_o   = oe_q;
  assign rd_o   = rd_q;
  assign cap_o  = cap_q;
  assign fail_o = fail_q;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int REG_W    = 32,
  parameter int ADDR_W   = REG_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  cmd_t                 cmd_q;
  logic                 busy, go, stat_fail;
  logic [DW-1:0]        faddr, wdat, cap;
  logic                 frame_act, frame_done, frame_rd, frame_fail;
  logic                 rise, fall;
  logic [FRAME_LEN-1:0] frame;
  logic [DW-1:0]        tx_data;

  mdio_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .done_i    (frame_done),
    .rd_frame_i(frame_rd),
    .cap_i     (cap),
    .fail_i    (frame_fail),
    .cmd_o     (cmd_q),
    .busy_o    (busy),
    .go_o      (go),
    .faddr_o   (faddr),
    .wdat_o    (wdat),
    .stat_o    (stat_fail),
    .rdata_o   (reg_rdata_o)
  );

  assign tx_data = (is_c45(cmd_q) && cmd_q.op == 2'd0) ? faddr : wdat;
  assign frame   = build_frame(cmd_q, tx_data);

  mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (frame_act),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_frame u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .frame_i(frame),
    .rd_i   (is_read(cmd_q)),
    .rise_i (rise),
    .fall_i (fall),
    .mdio_i (mdio_i),
    .act_o  (frame_act),
    .mdio_o (mdio_o),
    .oe_o   (mdio_oe_o),
    .done_o (frame_done),
    .rd_o   (frame_rd),
    .cap_o  (cap),
    .fail_o (frame_fail)
  );
endmodule

// File: rtl/mdio_chk.sv
module mdio_chk
  import mdio_pkg::*;
#(
  parameter int ADDR_W = REG_ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              start_i,
  input logic              mdc_o,
  input logic              mdio_o,
  input logic              mdio_oe_o,
  input logic              busy_i,
  input logic              act_i,
  input logic              done_i,
  input logic              rd_i,
  input logic [13:0]       cmd_i,
  input logic              stat_i
);
  logic cmd_wr;
  assign cmd_wr = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_CMD));

  // R8
  mdc_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_o);

  // R10
  oe_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdio_oe_o);

  // R8
  out_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && $past(act_i) && !$fell(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  // R9
  busy_cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cmd_wr) |=> $stable(cmd_i));

  // R3
  launch_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(cmd_wr && start_i));

  // R7
  stat_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stat_i) |-> $past(done_i && rd_i));
endmodule

bind mdio_mgmt_ctrl mdio_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_wr_i  (reg_wr_i),
  .reg_addr_i(reg_addr_i),
  .start_i   (reg_wdata_i[14]),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o),
  .busy_i    (busy),
  .act_i     (frame_act),
  .done_i    (frame_done),
  .rd_i      (frame_rd),
  .cmd_i     (cmd_q),
  .stat_i    (stat_fail)
);

// File: tb/sim_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_ctrl;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdo, moe, mdi;

  always #4 clk = ~clk;

  mdio_mgmt_ctrl #(.HALF_DIV(HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdo),
    .mdio_oe_o(moe), .mdio_i(mdi)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  logic [63:0] exp_bits_q[$];
  bit          exp_rd_q[$];
  string       exp_tag_q[$];
  int          frames_exp = 0;
  int          frames = 0;

  int          bit_n = 0;
  logic [63:0] got_bits, got_oe;
  logic [15:0] phy_data = '0;
  logic        phy_ta = 1'b0;

  assign mdi = (bit_n == 47) ? phy_ta :
               (bit_n >= 48) ? phy_data[(63 - bit_n) & 15] : 1'b1;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: PHY side capture and scoreboard compare
  always @(posedge mdc) begin
    got_bits[63 - bit_n] = mdo;
    got_oe[63 - bit_n]   = moe;
    bit_n++;
    if (bit_n == 64) begin
      logic [63:0] e, m;
      bit          r;
      string       t;
      bit_n = 0;
      frames++;
      if (exp_bits_q.size() == 0) begin
        chk(0, "R3", "unexpected frame", got_bits, 64'h0);
      end else begin
        e = exp_bits_q.pop_front();
        r = exp_rd_q.pop_front();
        t = exp_tag_q.pop_front();
        m = r ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        chk(got_oe == m, r ? "R6" : t, "output enable pattern", got_oe, m);
        chk((got_bits & m) == (e & m), t, "frame bits", got_bits & m, e & m);
      end
    end
  end

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    do reg_rd(5'h00, v); while (v[14]);
  endtask

  function automatic logic [63:0] exp_frame(logic [1:0] ft, logic [1:0] op,
      logic [4:0] prt, logic [4:0] dev, logic rd, logic [15:0] d);
    return {32'hFFFF_FFFF, (ft == 2'd0) ? 2'b00 : 2'b01, op, prt, dev,
            rd ? 2'b11 : 2'b10, d};
  endfunction

  task automatic launch(logic [1:0] ft, logic [1:0] op, logic [4:0] prt,
      logic [4:0] dev, logic rd, logic [15:0] d, string tag);
    exp_bits_q.push_back(exp_frame(ft, op, prt, dev, rd, d));
    exp_rd_q.push_back(rd);
    exp_tag_q.push_back(tag);
    frames_exp++;
    reg_wr(5'h00, {17'h0, 1'b1, ft, op, prt, dev});
  endtask

  task automatic finish_sim();
    if (!done_flag) begin
      done_flag = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [31:0] v;
    int          n;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a <= 16; a += 4) begin
      reg_rd(5'(a), v);
      chk(v == 0, "R1", "register after reset", 64'(v), 64'h0);
    end
    chk(mdc == 0 && moe == 0, "R1", "mdc/oe after reset", {mdc, moe}, 64'h0);

    // R2 field widths and offsets
    reg_wr(5'h04, 32'hFFFF_1234);
    reg_rd(5'h04, v);
    chk(v == 32'h0000_1234, "R2", "frame address reg", 64'(v), 64'h1234);
    reg_wr(5'h08, 32'hABCD_5678);
    reg_rd(5'h08, v);
    chk(v == 32'h0000_5678, "R2", "write data reg", 64'(v), 64'h5678);

    // R3 command without start: stored, no frame
    reg_wr(5'h00, 32'h0000_2A5F);
    repeat (100) @(posedge clk);
    reg_rd(5'h00, v);
    chk(v == 32'h0000_2A5F, "R3", "cmd without start", 64'(v), 64'h2A5F);
    chk(frames == 0 && mdc == 0, "R3", "no frame without start", 64'(frames), 64'h0);

    // R4 R5 R8 Clause 22 write, measure MDC period
    reg_wr(5'h08, 32'h0000_A5C3);
    launch(2'd1, 2'd1, 5'd5, 5'd3, 1'b0, 16'hA5C3, "R5");
    reg_rd(5'h00, v);
    chk(v[14] == 1'b1, "R3", "start bit reads busy", 64'(v[14]), 64'h1);
    @(posedge mdc);
    n = 0;
    @(posedge clk);
    while (!(mdc == 1'b0)) begin n++; @(posedge clk); end
    chk(n == HALF - 1 || n == HALF, "R8", "mdc high time", 64'(n), 64'(HALF));
    wait_idle();
    chk(frames == 1, "R4", "one frame per start", 64'(frames), 64'h1);

    // R5 Clause 45 address frame sends address reg, data frame sends write data
    reg_wr(5'h04, 32'h0000_BEEF);
    launch(2'd0, 2'd0, 5'd2, 5'd1, 1'b0, 16'hBEEF, "R5");
    wait_idle();
    reg_wr(5'h08, 32'h0000_0F0F);
    launch(2'd0, 2'd1, 5'd2, 5'd1, 1'b0, 16'h0F0F, "R4");
    wait_idle();

    // R6 Clause 22 read
    phy_data = 16'h1234;
    launch(2'd1, 2'd2, 5'd31, 5'd17, 1'b1, 16'h0, "R6");
    wait_idle();
    reg_rd(5'h0C, v);
    chk(v == 32'h1234, "R6", "c22 read data", 64'(v), 64'h1234);
    reg_rd(5'h10, v);
    chk(v == 0, "R7", "status after good read", 64'(v), 64'h0);

    // R6 Clause 45 read and read-increment
    phy_data = 16'hCAFE;
    launch(2'd0, 2'd3, 5'd9, 5'd30, 1'b1, 16'h0, "R6");
    wait_idle();
    reg_rd(5'h0C, v);
    chk(v == 32'hCAFE, "R6", "c45 read data", 64'(v), 64'hCAFE);
    phy_data = 16'h8001;
    launch(2'd0, 2'd2, 5'd0, 5'd7, 1'b1, 16'h0, "R6");
    wait_idle();
    reg_rd(5'h0C, v);
    chk(v == 32'h8001, "R6", "c45 read-inc data", 64'(v), 64'h8001);

    // R7 failed read, sticky across a write, cleared by good read
    phy_ta = 1'b1;
    launch(2'd1, 2'd2, 5'd4, 5'd1, 1'b1, 16'h0, "R7");
    wait_idle();
    reg_rd(5'h10, v);
    chk(v == 1, "R7", "status after failed read", 64'(v), 64'h1);
    launch(2'd1, 2'd1, 5'd4, 5'd1, 1'b0, 16'h0F0F, "R7");
    wait_idle();
    reg_rd(5'h10, v);
    chk(v == 1, "R7", "status kept by write", 64'(v), 64'h1);
    phy_ta = 1'b0;
    launch(2'd1, 2'd2, 5'd4, 5'd1, 1'b1, 16'h0, "R7");
    wait_idle();
    reg_rd(5'h10, v);
    chk(v == 0, "R7", "status cleared by good read", 64'(v), 64'h0);

    // R4 nonzero frame type other than 1 still uses Clause 22 start code
    launch(2'd2, 2'd1, 5'd3, 5'd3, 1'b0, 16'h0F0F, "R4");
    wait_idle();

    // R9 command write during a frame is ignored
    launch(2'd1, 2'd1, 5'd6, 5'd2, 1'b0, 16'h0F0F, "R9");
    repeat (100) @(posedge clk);
    reg_wr(5'h00, 32'h0000_7FFF);
    reg_rd(5'h00, v);
    chk(v == {17'h0, 1'b1, 2'd1, 2'd1, 5'd6, 5'd2}, "R9", "cmd during frame",
        64'(v), 64'({17'h0, 1'b1, 2'd1, 2'd1, 5'd6, 5'd2}));
    wait_idle();
    repeat (700) @(posedge clk);
    chk(frames == frames_exp, "R9", "no extra frame", 64'(frames), 64'(frames_exp));
    chk(mdc == 0 && moe == 0, "R10", "idle after frames", {mdc, moe}, 64'h0);
    chk(exp_bits_q.size() == 0, "R4", "all frames seen", 64'(exp_bits_q.size()), 64'h0);

    finish_sim();
  end
endmodule